// File: doc/BRIEF.md
# AAL1 Cell Payload Assembler

This block builds 48-byte AAL1 segmentation payloads from a byte stream that an external buffer supplies. Each payload opens with a one-byte protected header. The header holds an indication bit, a 3-bit cell count, a CRC-3 over those four bits and an even parity bit. User bytes follow the header. In structured mode, a cell with an even count can carry one pointer byte ahead of the user bytes. When timestamp transport is enabled, a 4-bit code is spread one bit at a time over the four odd-count cells of each eight-cell cycle.

The number of user bytes taken per cell is set by a fill level. It is clamped to the room left in the cell. Every remaining position carries a pad octet, which is held in a writable register. Configuration, pointer and code are read when the header byte leaves the block. The source stream is passed straight through to a valid/ready output that marks the 48th byte. No buffering sits on the path.

Top module: `aal1_sar_builder`

## Requirements
- R1: Each cell is exactly 48 output bytes. The header is byte 0. `out_last_o` is high on byte 47 and only there.
- R2: The header byte is {ind, count[2:0], crc[2:0], par}. The field crc is the remainder of ({ind,count}·x^3) divided by x^3+x+1. The bit par makes the byte's ones count even.
- R3: The cell count is 0 for the first cell after reset and rises by one per cell, modulo 8.
- R4: With `cfg_structured_i` low, a cell offers 47 user positions, and the indication bit of even-count cells is 0.
- R5: With `cfg_structured_i` and `ptr_valid_i` high at the header of an even-count cell, the indication bit is 1. Byte 1 is then {even parity of offset, ptr_offset_i[6:0]}, and 46 user positions remain.
- R6: For an odd-count cell, or with `ptr_valid_i` low, no pointer byte is sent and 47 user positions remain.
- R7: With `cfg_srts_en_i` high, the indication bit of the cells with counts 1, 3, 5 and 7 is code bit 3, 2, 1 and 0 respectively. The code is sampled at the header of the count-1 cell. With `cfg_srts_en_i` low, odd-count cells carry indication 0.
- R8: The first min(`cfg_fill_i`, room) user positions carry stream bytes in arrival order. All later positions carry the pad octet.
- R9: The pad octet resets to 0x6A and is replaced by `pad_value_i` on a cycle with `pad_we_i` high.
- R10: A stream byte is accepted only in the cycle that it leaves the output (`in_ready_o` implies `out_ready_i`). No byte is lost or duplicated under stalls on either side.
- R11: Mode, fill and pointer are taken at the header transfer. Changes made later in the cell do not alter that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_structured_i | input | 1 | Structured mode select |
| cfg_srts_en_i | input | 1 | Enable timestamp code transport |
| cfg_fill_i | input | FILL_W | User bytes per cell (clamped to room) |
| ptr_valid_i | input | 1 | Request a pointer byte in this cell |
| ptr_offset_i | input | 7 | Pointer offset value |
| srts_code_i | input | 4 | 4-bit timestamp code |
| pad_we_i | input | 1 | Pad octet write strobe |
| pad_value_i | input | 8 | New pad octet |
| in_valid_i | input | 1 | Source byte valid |
| in_data_i | input | 8 | Source byte |
| in_ready_o | output | 1 | Source byte taken |
| out_valid_o | output | 1 | Payload byte valid |
| out_data_o | output | 8 | Payload byte |
| out_last_o | output | 1 | Byte 47 of the cell |
| out_ready_i | input | 1 | Sink accepts byte |

## Verification
The bench runs the count through its wrap from 7 to 0. It checks whether the header CRC and parity track the indication bit. A design that computed the CRC over the count alone would show wrong headers only on cells with the indication bit set. It asks for pointers on odd-count cells and in unstructured mode, where a design that obeyed the request would shift every user byte by one. It runs fills of 0, of exactly the room and of more than the room, where an off-by-one limit shows as a stream byte in place of pad or as a lost byte. It changes the fill and the mode in the middle of a cell and writes the pad octet between cells. It randomly stalls both the source and the sink, so that a design that took a source byte without sending it would drift the stream for the rest of the run.

// File: rtl/aal1_pkg.sv
package aal1_pkg;
  localparam int unsigned CELL_BYTES = 48;
  localparam int unsigned IDX_W      = $clog2(CELL_BYTES);
  localparam int unsigned PTR_W      = 7;
  localparam int unsigned CODE_W     = 4;

  // remainder of (sn * x^3) mod x^3+x+1, serial form
  function automatic logic [2:0] crc3(input logic [3:0] sn);
    logic [2:0] r;
    logic       fb;
    r = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      fb = sn[i] ^ r[2];
      r  = {r[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
    end
    return r;
  endfunction
endpackage

// File: rtl/aal1_seq_ctrl.sv
module aal1_seq_ctrl
  import aal1_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              srts_en_i,
  input  logic [CODE_W-1:0] srts_code_i,
  input  logic              ptr_here_i,
  output logic [2:0]        sc_o,
  output logic              ind_o
);
  logic [2:0]        sc_q;
  logic [CODE_W-1:0] hold_q;
  logic              srts_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q   <= '0;
      hold_q <= '0;
    end else if (adv_i) begin
      sc_q <= sc_q + 3'd1;
      if (sc_q == 3'd1) hold_q <= srts_code_i;
    end
  end

  // count 1 uses the live code; 3,5,7 use the copy taken at count 1
  always_comb begin
    if (sc_q == 3'd1) srts_bit = srts_code_i[CODE_W-1];
    else              srts_bit = hold_q[2'd3 - sc_q[2:1]];
  end

  assign sc_o  = sc_q;
  assign ind_o = sc_q[0] ? (srts_en_i & srts_bit) : ptr_here_i;
endmodule

// File: rtl/aal1_hdr_gen.sv
module aal1_hdr_gen
  import aal1_pkg::*;
(
  input  logic [2:0] sc_i,
  input  logic       ind_i,
  output logic [7:0] hdr_o
);
  logic [2:0] crc;
  assign crc   = crc3({ind_i, sc_i});
  assign hdr_o = {ind_i, sc_i, crc, ^{ind_i, sc_i, crc}};
endmodule

// File: rtl/aal1_sar_builder.sv
module aal1_sar_builder
  import aal1_pkg::*;
#(
  parameter int unsigned FILL_W    = 6,
  parameter logic [7:0]  PAD_RESET = 8'h6A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_structured_i,
  input  logic              cfg_srts_en_i,
  input  logic [FILL_W-1:0] cfg_fill_i,
  input  logic              ptr_valid_i,
  input  logic [PTR_W-1:0]  ptr_offset_i,
  input  logic [CODE_W-1:0] srts_code_i,
  input  logic              pad_we_i,
  input  logic [7:0]        pad_value_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] ROOM_STD = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] ROOM_PTR = IDX_W'(CELL_BYTES - 2);

  logic [IDX_W-1:0] idx_q;
  logic             cell_ptr_q;
  logic [IDX_W-1:0] cell_fill_q;
  logic [PTR_W-1:0] cell_off_q;
  logic [7:0]       pad_q;

  logic [2:0]       sc;
  logic             ind;
  logic [7:0]       hdr;
  logic             ptr_here;
  logic [IDX_W-1:0] room, fill_eff, user_pos;
  logic             is_hdr, is_ptr, is_data, fire, hdr_fire;

  assign ptr_here = cfg_structured_i & ptr_valid_i & ~sc[0];
  assign room     = ptr_here ? ROOM_PTR : ROOM_STD;
  assign fill_eff = (cfg_fill_i > FILL_W'(room)) ? room : cfg_fill_i[IDX_W-1:0];

  aal1_seq_ctrl i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (hdr_fire),
    .srts_en_i   (cfg_srts_en_i),
    .srts_code_i (srts_code_i),
    .ptr_here_i  (ptr_here),
    .sc_o        (sc),
    .ind_o       (ind)
  );

  aal1_hdr_gen i_hdr (
    .sc_i  (sc),
    .ind_i (ind),
    .hdr_o (hdr)
  );

  assign user_pos = idx_q - IDX_W'(1) - IDX_W'(cell_ptr_q);
  assign is_hdr   = (idx_q == '0);
  assign is_ptr   = cell_ptr_q && (idx_q == IDX_W'(1));
  assign is_data  = !is_hdr && !is_ptr && (user_pos < cell_fill_q);

  assign out_valid_o = is_data ? in_valid_i : 1'b1;
  assign in_ready_o  = is_data & out_ready_i;
  assign out_last_o  = (idx_q == LAST_IDX);
  assign fire        = out_valid_o & out_ready_i;
  assign hdr_fire    = fire & is_hdr;

  always_comb begin
    if (is_hdr)       out_data_o = hdr;
    else if (is_ptr)  out_data_o = {^cell_off_q, cell_off_q};
    else if (is_data) out_data_o = in_data_i;
    else              out_data_o = pad_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      cell_ptr_q  <= 1'b0;
      cell_fill_q <= '0;
      cell_off_q  <= '0;
    end else if (fire) begin
      idx_q <= out_last_o ? '0 : idx_q + IDX_W'(1);
      if (is_hdr) begin
        cell_ptr_q  <= ptr_here;
        cell_fill_q <= fill_eff;
        cell_off_q  <= ptr_offset_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pad_q <= PAD_RESET;
    else if (pad_we_i) pad_q <= pad_value_i;
  end
endmodule

// File: rtl/aal1_sar_builder_chk.sv
module aal1_sar_builder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic [7:0] in_data_i,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_last_o,
  input logic       out_ready_i
);
  logic [5:0] cnt_q;
  logic [2:0] prev_sc_q;
  logic       seen_q, ptr_next_q;
  logic       hs;

  assign hs = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      prev_sc_q  <= '0;
      seen_q     <= 1'b0;
      ptr_next_q <= 1'b0;
    end else if (hs) begin
      cnt_q <= (cnt_q == 6'd47) ? 6'd0 : cnt_q + 6'd1;
      if (cnt_q == 6'd0) begin
        prev_sc_q  <= out_data_o[6:4];
        seen_q     <= 1'b1;
        ptr_next_q <= out_data_o[7] & ~out_data_o[4];
      end
    end
  end

  assert_last_pos_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_last_o == (cnt_q == 6'd47)));

  assert_hdr_parity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && cnt_q == 6'd0) |-> (^out_data_o == 1'b0));

  assert_seq_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && cnt_q == 6'd0 && seen_q) |-> (out_data_o[6:4] == 3'(prev_sc_q + 3'd1)));

  assert_ptr_parity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && cnt_q == 6'd1 && ptr_next_q) |-> (^out_data_o == 1'b0));

  assert_take_on_send_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> (hs && out_data_o == in_data_i));

  assert_ready_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> out_ready_i);
endmodule

bind aal1_sar_builder aal1_sar_builder_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .out_ready_i (out_ready_i)
);

// File: tb/test_aal1_sar_builder.sv
module test_aal1_sar_builder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_structured_i = 1'b0;
  logic       cfg_srts_en_i = 1'b0;
  logic [5:0] cfg_fill_i = 6'd0;
  logic       ptr_valid_i = 1'b0;
  logic [6:0] ptr_offset_i = 7'd0;
  logic [3:0] srts_code_i = 4'd0;
  logic       pad_we_i = 1'b0;
  logic [7:0] pad_value_i = 8'd0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i;
  logic       in_ready_o, out_valid_o, out_last_o;
  logic [7:0] out_data_o;
  logic       out_ready_i = 1'b0;

  always #4 clk_i = ~clk_i;

  aal1_sar_builder i_aal1_sar_builder (
    .clk_i, .rst_ni, .cfg_structured_i, .cfg_srts_en_i, .cfg_fill_i,
    .ptr_valid_i, .ptr_offset_i, .srts_code_i, .pad_we_i, .pad_value_i,
    .in_valid_i, .in_data_i, .in_ready_o, .out_valid_o, .out_data_o,
    .out_last_o, .out_ready_i
  );

  typedef struct packed { logic [7:0] d; logic l; } exp_t;
  exp_t exp_q[$];

  int   checks = 0, errors = 0, cells_done = 0, cells_issued = 0;
  bit   hold_rdy = 1'b1;
  logic [7:0] src = 8'd0;
  // bench model state
  int         m_sc = 0;
  logic [7:0] m_src = 8'd0;
  logic [7:0] m_pad = 8'h6A;
  logic [3:0] m_hold = 4'd0;

  assign in_data_i = src;

  always @(posedge clk_i) begin
    if (in_valid_i && in_ready_o) src <= src + 8'd1;
    if (out_valid_o && out_ready_i && out_last_o) cells_done <= cells_done + 1;
  end

  function automatic logic [2:0] ref_crc(input logic [3:0] sn);
    logic [6:0] v;
    v = {sn, 3'b000};
    for (int i = 6; i >= 3; i--)
      if (v[i]) v = v ^ (7'b1011 << (i - 3));
    return v[2:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: random sink/source stalls, compare against scoreboard
  always @(negedge clk_i) begin
    out_ready_i = hold_rdy ? 1'b0 : ($urandom_range(0, 9) < 7);
    in_valid_i  = ($urandom_range(0, 9) < 8);
    #1;
    if (out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        chk("R1 unexpected byte", 32'(out_data_o), 32'hFFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R1/R2/R5/R7/R8 data", 32'(out_data_o), 32'(e.d));
        chk("R1 last flag", 32'(out_last_o), 32'(e.l));
      end
    end
  end

  // driver: set config for next cell and push its expected bytes
  task automatic run_cell(input bit st, input bit se, input int fill, input bit pv,
                          input logic [6:0] off, input logic [3:0] code,
                          input bit mid_change);
    bit   ptr_here, ind;
    int   room, eff, pos;
    logic [2:0] sc3;
    logic [7:0] h;
    exp_t e;
    cfg_structured_i = st;  cfg_srts_en_i = se;  cfg_fill_i = 6'(fill);
    ptr_valid_i = pv;  ptr_offset_i = off;  srts_code_i = code;
    sc3 = 3'(m_sc);
    ptr_here = st && pv && !sc3[0];           // R5 / R6
    if (sc3 == 3'd1) m_hold = code;
    if (sc3[0]) ind = se && m_hold[3 - (m_sc / 2)];  // R7
    else        ind = ptr_here;                        // R4 / R5
    h = {ind, sc3, ref_crc({ind, sc3}), 1'b0};
    h[0] = ^h[7:1];                                    // R2
    e.d = h; e.l = 1'b0; exp_q.push_back(e);
    pos = 1;
    if (ptr_here) begin
      e.d = {^off, off}; e.l = 1'b0; exp_q.push_back(e); pos++;
    end
    room = ptr_here ? 46 : 47;
    eff  = (fill > room) ? room : fill;                // R8
    for (int k = 0; k < room; k++) begin
      e.d = (k < eff) ? m_src : m_pad;
      if (k < eff) m_src = m_src + 8'd1;
      e.l = (pos == 47);
      exp_q.push_back(e);
      pos++;
    end
    m_sc = (m_sc + 1) % 8;                             // R3
    cells_issued++;
    hold_rdy = 1'b0;
    if (mid_change) begin                              // R11
      repeat (6) @(posedge clk_i);
      #1;
      cfg_structured_i = ~st; cfg_fill_i = 6'(fill ^ 13);
      ptr_valid_i = ~pv; ptr_offset_i = ~off;
    end
    wait (cells_done == cells_issued);
    #1;
    chk("R1 cell drained", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic write_pad(input logic [7:0] v);       // R9
    hold_rdy = 1'b1;
    @(posedge clk_i); #1;
    pad_we_i = 1'b1; pad_value_i = v;
    @(posedge clk_i); #1;
    pad_we_i = 1'b0;
    m_pad = v;
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk_i);
    #1;
    // reset state: header of count 0 offered, nothing taken
    chk("R3 reset valid", 32'(out_valid_o), 32'd1);
    chk("R2 reset header", 32'(out_data_o), 32'h00);
    chk("R1 reset last", 32'(out_last_o), 32'd0);
    chk("R10 reset ready", 32'(in_ready_o), 32'd0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    run_cell(0, 0, 47, 1, 7'h11, 4'h0, 0);   // R4: sc0, pointer ignored
    run_cell(0, 1, 47, 0, 7'h00, 4'hA, 0);   // R7: code sampled at sc1
    run_cell(1, 1, 63, 1, 7'h15, 4'h3, 0);   // R5: clamp fill to 46
    run_cell(1, 1, 20, 1, 7'h2B, 4'hF, 0);   // R6: odd count, pad 0x6A
    run_cell(1, 0,  0, 0, 7'h00, 4'h0, 0);   // R8: fill 0 all pad
    run_cell(0, 1, 10, 0, 7'h00, 4'h0, 0);   // R7 sc5
    run_cell(1, 1, 46, 1, 7'h00, 4'h0, 0);   // R5 exact room
    run_cell(0, 1, 47, 0, 7'h00, 4'h0, 0);   // R7 sc7
    write_pad(8'hC3);                         // R9
    run_cell(1, 0,  5, 1, 7'h7F, 4'h0, 0);   // R3 wrap to 0, R9 new pad
    run_cell(1, 1, 30, 1, 7'h05, 4'h5, 1);   // R11 mid change, R7 new code
    run_cell(1, 0, 12, 1, 7'h44, 4'h0, 1);   // R11 pointer cell mid change
    for (int n = 0; n < 20; n++)
      run_cell(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               $urandom_range(0, 63), 1'($urandom_range(0, 1)),
               7'($urandom_range(0, 127)), 4'($urandom_range(0, 15)),
               1'($urandom_range(0, 1)));
    hold_rdy = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R10 stream count", 32'(src), 32'(m_src));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule